// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block produces a regular system tick interrupt. Software first writes a period value into a divider register. It then writes a load operation into the control register, which copies the divider into the counter, and after that a run operation. While running, the counter steps down once per count edge. Count edges come at a programmable fraction of the clock rate: one edge every 2^rate clock cycles. When the counter would pass below one, it takes the divider value again and raises a pending interrupt flag. The tick period is therefore exactly the divider value in count edges.

The live count can be read at any time. Elapsed time inside the current period is the divider minus the count. The pending flag stays set until software acknowledges it by writing a one. A mask register gates the flag onto the interrupt output. A masked-status register lets a shared interrupt handler tell whether the request came from this timer. The divider may be rewritten while the timer runs, and the new value is used from the next reload.

Register map (word addresses): 0 divider (read/write), 1 control (read/write), 2 live count (read only), 3 mask (read/write, bit 0), 4 acknowledge (write only, reads 0), 5 raw pending (read only, bit 0), 6 masked pending (read only, bit 0). Control holds the operation in bits [1:0] (0 idle, 1 load, 2 run, 3 idle) and the rate select in bits [5:4].

Top module: `tick_timer`

## Requirements
- R1: After reset the divider, control, mask, count and pending flag all read 0, and irq is low.
- R2: While the control operation is load (1), the count equals the divider and does not step.
- R3: While the operation is run (2), the count decreases by one on each count edge. With rate select s in control bits [5:4], a count edge occurs every 2^s clocks, the first one 2^s clocks after the run write.
- R4: On a count edge where the count is 1 (or 0), the count reloads from the divider and the pending flag (address 5, bit 0) is set, so a divider d gives one expiry every d count edges.
- R5: Writing the divider while running leaves the live count unchanged, and the new value is loaded at the next reload.
- R6: With operation 0 or 3 the count holds its value, and a set pending flag stays set.
- R7: Writing address 4 with bit 0 = 1 clears the pending flag, and with bit 0 = 0 it has no effect. An expiry in the same cycle as an acknowledge leaves the flag set.
- R8: The masked-status register (address 6, bit 0) and the irq output equal the pending flag ANDed with mask bit 0.
- R9: Reads return the register map above: the divider and mask as written, control as {rate, 2'b00, op} in bits [5:0], and 0 at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that only one register write arrives per cycle and that the rate select does not change while counting. They also assume that load and run are never active together, which the two-bit operation field guarantees. The stimulus changes the rate only while the operation is load, so the prescaler always starts from zero when a run begins. A sweep over small divider values and every rate select compares the live count and the pending flag on each cycle against the arithmetic expectation, divider minus (edges mod divider). Directed sequences cover the mid-run divider rewrite, the idle freeze, the acknowledge collision and masking.

// File: rtl/tt_pkg.sv
// Shared definitions for the tick timer: operation codes and the register map.
// Assumes word addressing; addresses fit in three bits.
package tt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_RUN  = 2'd2,
        OP_HALT = 2'd3
    } tt_op_e;

    localparam int A_DIV    = 0;
    localparam int A_CTRL   = 1;
    localparam int A_COUNT  = 2;
    localparam int A_MASK   = 3;
    localparam int A_ACK    = 4;
    localparam int A_RAW    = 5;
    localparam int A_MASKED = 6;

    localparam int OP_LSB   = 0;
    localparam int RATE_LSB = 4;

endpackage

// File: rtl/tt_prescale.sv
// Count-edge generator: while running, asserts tick_o once every 2^rate_i clocks.
// Assumes rate_i stays constant while run_i is high; clears its phase when stopped
// so that the first edge lands 2^rate_i clocks after running starts.
module tt_prescale #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    localparam int PRE_W = (1 << RATE_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Build the low-bit mask selecting a 2^rate phase.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(rate_i));
        end
    end

    // Phase counter runs only while counting is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) pre_q <= '0;
        else                  pre_q <= pre_q + 1'b1;
    end

    assign tick_o = run_i && ((pre_q & mask) == mask);

    // Back-to-back edges only happen at the fastest rate.
    p_spaced_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i != '0 && $past(rate_i) == rate_i && $past(tick_o)) |-> !tick_o);

endmodule

// File: rtl/tt_counter.sv
// Down counter with reload: holds the divider while loading, steps down on
// each tick, and reloads from the divider when a tick meets a count of 1 or 0.
// Assumes load_i and tick_i are never both high.
module tt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] div_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] count_q;
    logic             at_end;

    assign at_end   = (count_q <= CNT_W'(1));
    assign expire_o = tick_i && !load_i && at_end;

    // Load, step or reload the live count.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (load_i)  count_q <= div_i;
        else if (tick_i)  count_q <= at_end ? div_i : count_q - 1'b1;
    end

    assign count_o = count_q;

    p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_o == $past(div_i));
    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && count_o > CNT_W'(1)) |=> count_o == $past(count_o) - 1'b1);
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> count_o == $past(div_i));
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(count_o));

endmodule

// File: rtl/tt_irq.sv
// Pending-interrupt flag: set by an expiry, cleared by an acknowledge, with the
// expiry winning a same-cycle collision; the masked view feeds irq.
module tt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic mask_i,
    output logic pending_o,
    output logic masked_o
);
    logic pending_q;

    // Sticky flag with set priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending_q <= 1'b0;
        else if (set_i)  pending_q <= 1'b1;
        else if (ack_i)  pending_q <= 1'b0;
    end

    assign pending_o = pending_q;
    assign masked_o  = pending_q & mask_i;

    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pending_o);
    p_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !ack_i) |=> pending_o);
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !pending_o);
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending_o && !set_i) |=> !pending_o);

endmodule

// File: rtl/tick_timer.sv
// Top of the periodic tick timer: register file, write decode, read mux, and the
// prescaler, counter and interrupt flag beneath. Assumes one write per cycle and
// that CNT_W is at least 6 so the control fields fit.
module tick_timer
    import tt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] AD_DIV    = ADDR_W'(A_DIV);
    localparam logic [ADDR_W-1:0] AD_CTRL   = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_COUNT  = ADDR_W'(A_COUNT);
    localparam logic [ADDR_W-1:0] AD_MASK   = ADDR_W'(A_MASK);
    localparam logic [ADDR_W-1:0] AD_ACK    = ADDR_W'(A_ACK);
    localparam logic [ADDR_W-1:0] AD_RAW    = ADDR_W'(A_RAW);
    localparam logic [ADDR_W-1:0] AD_MASKED = ADDR_W'(A_MASKED);
    localparam int CTRL_PAD = CNT_W - RATE_LSB - RATE_W;

    logic [CNT_W-1:0]  div_q;
    tt_op_e            op_q;
    logic [RATE_W-1:0] rate_q;
    logic              mask_q;

    logic              running, loading, tick, expire, ack, pending, masked;
    logic [CNT_W-1:0]  count;

    assign running = (op_q == OP_RUN);
    assign loading = (op_q == OP_LOAD);
    assign ack     = wr_en && (wr_addr == AD_ACK) && wr_data[0];

    // Software-writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            op_q   <= OP_IDLE;
            rate_q <= '0;
            mask_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == AD_DIV)  div_q <= wr_data;
            if (wr_addr == AD_CTRL) begin
                op_q   <= tt_op_e'(wr_data[OP_LSB +: 2]);
                rate_q <= wr_data[RATE_LSB +: RATE_W];
            end
            if (wr_addr == AD_MASK) mask_q <= wr_data[0];
        end
    end

    tt_prescale #(.RATE_W(RATE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .rate_i (rate_q),
        .tick_o (tick)
    );

    tt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (loading),
        .tick_i   (tick),
        .div_i    (div_q),
        .count_o  (count),
        .expire_o (expire)
    );

    tt_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (expire),
        .ack_i     (ack),
        .mask_i    (mask_q),
        .pending_o (pending),
        .masked_o  (masked)
    );

    // Combinational read multiplexer over the register map.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            AD_DIV:    rd_data = div_q;
            AD_CTRL:   rd_data = {{CTRL_PAD{1'b0}}, rate_q, 2'b00, op_q};
            AD_COUNT:  rd_data = count;
            AD_MASK:   rd_data = {{(CNT_W-1){1'b0}}, mask_q};
            AD_RAW:    rd_data = {{(CNT_W-1){1'b0}}, pending};
            AD_MASKED: rd_data = {{(CNT_W-1){1'b0}}, masked};
            default:   rd_data = '0;
        endcase
    end

    assign irq = masked;

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q && pending));
    p_count_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !loading) |=> $stable(count));

endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
    localparam int CW = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tick_timer #(.CNT_W(CW), .ADDR_W(AW), .RATE_W(2)) u_tick_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [CW-1:0] got, input logic [CW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [CW-1:0] v);
        rd_addr = AW'(a);
        #1;
        v = rd_data;
    endtask

    task automatic wr(input int a, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset values
        for (int a = 0; a < 7; a++) begin
            rd(a, v); chk("R1 reset register", v, 0);
        end
        chk("R1 irq low", {31'd0, irq}, 0);

        // R2/R3/R4: sweep divider and rate, check every cycle arithmetically
        for (int d = 1; d <= 6; d++) begin
            for (int s = 0; s < 4; s++) begin
                wr(0, d);
                wr(1, 32'h1 | (s << 4));
                wr(4, 1);
                rd(2, v); chk("R2 load copies divider", v, d);
                step(2);
                rd(2, v); chk("R2 no counting in load", v, d);
                rd(5, v); chk("R2 no pending in load", v, 0);
                wr(1, 32'h2 | (s << 4));
                rd(2, v); chk("R3 count at run start", v, d);
                for (int k = 1; k <= 3 * d * (1 << s); k++) begin
                    int ticks;
                    step(1);
                    ticks = k >> s;
                    rd(2, v); chk("R3 R4 live count", v, d - (ticks % d));
                    rd(5, v); chk("R4 pending", v, (ticks >= d) ? 1 : 0);
                end
            end
        end

        // R5: divider rewrite while running
        wr(0, 5); wr(1, 1); wr(4, 1); wr(1, 2);
        wr(0, 3);
        rd(2, v); chk("R5 count unaffected by divider write", v, 4);
        step(3);
        rd(2, v); chk("R5 count reaches 1", v, 1);
        rd(5, v); chk("R5 no pending yet", v, 0);
        step(1);
        rd(2, v); chk("R5 new divider at reload", v, 3);
        rd(5, v); chk("R5 pending at reload", v, 1);

        // R6: idle freezes count and holds pending
        wr(0, 3); wr(1, 1); wr(4, 1); wr(1, 2);
        step(4);
        rd(2, v); chk("R6 count before stop", v, 2);
        rd(5, v); chk("R6 pending before stop", v, 1);
        wr(1, 0);
        rd(2, v); chk("R6 last step on stop edge", v, 1);
        step(5);
        rd(2, v); chk("R6 idle freezes count", v, 1);
        rd(5, v); chk("R6 idle holds pending", v, 1);
        wr(1, 3);
        step(4);
        rd(2, v); chk("R6 op 3 freezes count", v, 1);

        // R8: masking
        rd(6, v); chk("R8 masked off", v, 0);
        chk("R8 irq off when masked", {31'd0, irq}, 0);
        wr(3, 1);
        rd(6, v); chk("R8 masked on", v, 1);
        chk("R8 irq on", {31'd0, irq}, 1);

        // R9: readback
        rd(0, v); chk("R9 divider readback", v, 3);
        rd(1, v); chk("R9 control readback", v, 3);
        rd(3, v); chk("R9 mask readback", v, 1);
        rd(4, v); chk("R9 ack reads zero", v, 0);

        // R7: acknowledge
        wr(4, 0);
        rd(5, v); chk("R7 ack bit0=0 ignored", v, 1);
        chk("R7 irq kept", {31'd0, irq}, 1);
        wr(4, 1);
        rd(5, v); chk("R7 ack clears", v, 0);
        chk("R7 irq cleared", {31'd0, irq}, 0);
        rd(6, v); chk("R8 masked follows ack", v, 0);

        // R7: collision with expiry every edge
        wr(0, 1); wr(1, 1); wr(1, 2);
        step(2);
        wr(4, 1);
        rd(5, v); chk("R7 expiry beats ack", v, 1);

        done = 1;
        summary();
        $finish;
    end
endmodule